// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block is the erase engine of a serial NOR flash slave model. It listens on the SPI pins and recognises three commands that erase a block of 4 KiB, 32 KiB or 64 KiB, two equivalent commands that clear the whole array, and a write-enable command that arms the write-enable latch. A block erase carries a 24-bit address. Whatever byte that address names, the engine moves it down to the start of the block that holds it and clears the whole block.

A command is accepted when chip select is released. It runs only if the write-enable latch is set and the protect input is low. The engine then drives a write port into the byte array at one byte per system clock, writing 0xFF at ascending addresses while the busy output is high. When the last byte is written, busy drops and the write-enable latch clears in the same clock edge.

The array is smaller than a real part. The block sizes are divided by a power of two set by a parameter, so that the array can hold several blocks of each size.

Top module: `flash_erase_seq`

## Requirements
- R1: Block erase opcodes and region sizes. Opcode 0x20 erases a block of 2^(12-SIZE_SHIFT) bytes, 0x52 a block of 2^(15-SIZE_SHIFT) bytes and 0xD8 a block of 2^(16-SIZE_SHIFT) bytes. The erased region starts at the address with its low bits cleared to the block boundary and covers the whole block. With the defaults these sizes are 64, 512 and 1024 bytes.
- R2: Opcodes 0x60 and 0xC7 each erase the whole array of 2^ADDR_W bytes from address 0. Either one is accepted only when exactly 8 bits were clocked in that frame; with any other count it is discarded.
- R3: A block erase is accepted only when exactly 32 bits (8 of opcode, then 24 of address, MSB first) were clocked in before chip select rose. Fewer or more bits discard the command.
- R4: An erase starts only if the write-enable latch is set and protect is low. A command rejected for either reason produces no write and leaves the write-enable latch unchanged.
- R5: Opcode 0x06 with exactly 8 bits, received while not busy, sets the write-enable latch. The same opcode with another bit count has no effect.
- R6: During an erase, wr_en is high for exactly one cycle per byte of the region. wr_data is 0xFF, wr_addr starts at the aligned base and rises by one each cycle, and no write occurs while busy is low.
- R7: Busy rises within 6 clock cycles after chip select rises on an accepted erase. The write-enable latch is already clear in the first cycle after busy falls.
- R8: A command of any kind that completes while busy is high is ignored. It neither restarts nor extends the erase, and it does not set the write-enable latch.
- R9: MOSI is sampled on the rising edge of SCLK, MSB first. Address bits at and above ADDR_W are ignored.
- R10: After reset, busy, wel and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, asynchronous to clk |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data in |
| protect | input | 1 | High blocks every erase |
| wr_en | output | 1 | Array write strobe, one byte per cycle |
| wr_addr | output | ADDR_W | Array byte address |
| wr_data | output | 8 | Array write data (erased value) |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | High while an erase is running |

## Verification
A wrong block size or a wrong alignment shows up as bytes outside the expected region that were cleared, or bytes inside it that were not. The bench sees this as soon as busy falls, by comparing its own copy of the array. A wrong bit count or a broken opcode decode shows up within about six cycles of chip select rising: busy either fails to rise or rises when it should not. A stuck or skipping address counter breaks the rule that each write address is one above the last, on the very next write. A stale write-enable latch is visible on the wel pin one cycle after the erase ends, and again when the next command is rejected.

// File: rtl/fes_pkg.sv
package fes_pkg;

  localparam int CNT_W     = 6;
  localparam int FRAME_W   = 32;
  localparam int OP_BITS   = 8;
  localparam int ADDR_BITS = 24;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_ERASE_S = 8'h20;
  localparam logic [7:0] OP_ERASE_M = 8'h52;
  localparam logic [7:0] OP_ERASE_L = 8'hD8;
  localparam logic [7:0] OP_CHIP_A  = 8'h60;
  localparam logic [7:0] OP_CHIP_B  = 8'hC7;
  localparam logic [7:0] ERASED     = 8'hFF;

  typedef enum logic [2:0] {
    K_NONE, K_WREN, K_BLK_S, K_BLK_M, K_BLK_L, K_CHIP
  } cmd_kind_t;

  // Classify a finished frame by its exact bit count and opcode.
  function automatic cmd_kind_t classify(logic [CNT_W-1:0] n, logic [FRAME_W-1:0] sh);
    cmd_kind_t k;
    k = K_NONE;
    if (n == CNT_W'(OP_BITS)) begin
      case (sh[7:0])
        OP_WREN:              k = K_WREN;
        OP_CHIP_A, OP_CHIP_B: k = K_CHIP;
        default:              k = K_NONE;
      endcase
    end else if (n == CNT_W'(OP_BITS + ADDR_BITS)) begin
      case (sh[31:24])
        OP_ERASE_S: k = K_BLK_S;
        OP_ERASE_M: k = K_BLK_M;
        OP_ERASE_L: k = K_BLK_L;
        default:    k = K_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic is_erase(cmd_kind_t k);
    return (k == K_BLK_S) || (k == K_BLK_M) || (k == K_BLK_L) || (k == K_CHIP);
  endfunction

  // log2 of the region size in bytes, clamped to the array.
  function automatic int region_lg(cmd_kind_t k, int shift, int aw);
    int lg;
    case (k)
      K_BLK_S: lg = 12 - shift;
      K_BLK_M: lg = 15 - shift;
      K_BLK_L: lg = 16 - shift;
      K_CHIP:  lg = aw;
      default: lg = 0;
    endcase
    if (lg < 0)  lg = 0;
    if (lg > aw) lg = aw;
    return lg;
  endfunction

  // Region size minus one, which is also the in-block offset mask.
  function automatic logic [ADDR_BITS-1:0] region_last(int lg);
    logic [ADDR_BITS-1:0] m;
    if (lg <= 0) m = '0;
    else         m = {ADDR_BITS{1'b1}} >> (ADDR_BITS - lg);
    return m;
  endfunction

  function automatic logic [ADDR_BITS-1:0] align_down(logic [ADDR_BITS-1:0] a, int lg);
    return a & ~region_last(lg);
  endfunction

endpackage

// File: rtl/fes_spi_rx.sv
module fes_spi_rx
  import fes_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               frame_end,
  output logic [CNT_W-1:0]   nbits,
  output logic [FRAME_W-1:0] shreg
);

  logic [SYNC-1:0] sclk_s, cs_s, mosi_s;
  logic            sclk_d, cs_d;
  logic            sclk_rise, cs_high;
  logic [CNT_W-1:0] cnt_q;
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC-2:0], sclk};
      cs_s   <= {cs_s[SYNC-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC-2:0], mosi};
      sclk_d <= sclk_s[SYNC-1];
      cs_d   <= cs_s[SYNC-1];
    end
  end

  assign sclk_rise = sclk_s[SYNC-1] & ~sclk_d;
  assign cs_high   = cs_s[SYNC-1];
  assign frame_end = cs_high & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cs_high) begin
      cnt_q <= '0;
    end else if (sclk_rise) begin
      sh_q <= {sh_q[FRAME_W-2:0], mosi_s[SYNC-1]};
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign nbits = cnt_q;
  assign shreg = sh_q;

  a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_high) && cs_high |-> nbits == '0);

endmodule

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
  import fes_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SIZE_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [CNT_W-1:0]   nbits,
  input  logic [FRAME_W-1:0] shreg,
  input  logic               wel,
  input  logic               protect,
  input  logic               busy,
  output logic               start,
  output logic [ADDR_W-1:0]  base,
  output logic [ADDR_W-1:0]  last,
  output logic               set_wel
);

  cmd_kind_t            kind_w;
  int                   lg_w;
  logic [ADDR_BITS-1:0] last_w, base_w;
  logic                 erase_go, wren_go;
  logic                 start_q, set_wel_q;
  logic [ADDR_W-1:0]    base_q, last_q;

  always_comb begin
    kind_w = classify(nbits, shreg);
    lg_w   = region_lg(kind_w, SIZE_SHIFT, ADDR_W);
    last_w = region_last(lg_w);
    base_w = align_down(shreg[ADDR_BITS-1:0], lg_w);
  end

  assign erase_go = frame_end & is_erase(kind_w) & wel & ~protect & ~busy;
  assign wren_go  = frame_end & (kind_w == K_WREN) & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      set_wel_q <= 1'b0;
      base_q    <= '0;
      last_q    <= '0;
    end else begin
      start_q   <= erase_go;
      set_wel_q <= wren_go;
      if (erase_go) begin
        base_q <= base_w[ADDR_W-1:0];
        last_q <= last_w[ADDR_W-1:0];
      end
    end
  end

  assign start   = start_q;
  assign base    = base_q;
  assign last    = last_q;
  assign set_wel = set_wel_q;

  // R3 / R2: only frames of exactly 8 or 32 bits can launch an erase
  a_r3_exact_length: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $past(nbits == CNT_W'(OP_BITS) || nbits == CNT_W'(OP_BITS + ADDR_BITS)));

endmodule

// File: rtl/fes_walker.sv
module fes_walker
  import fes_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] last,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic              busy_q;
  logic [ADDR_W-1:0] addr_q, remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
    end else if (start && !busy_q) begin
      busy_q   <= 1'b1;
      addr_q   <= base;
      remain_q <= last;
    end else if (busy_q) begin
      if (remain_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        addr_q   <= addr_q + 1'b1;
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && (remain_q == '0);
  assign wr_en   = busy_q;
  assign wr_addr = addr_q;
  assign wr_data = ERASED;

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  a_r1_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (base & last) == '0);

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> addr_q == ADDR_W'($past(addr_q) + 1'b1));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SIZE_SHIFT  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              protect,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wel,
  output logic              busy
);

  logic               frame_end;
  logic [CNT_W-1:0]   nbits;
  logic [FRAME_W-1:0] shreg;
  logic               start_evt, set_wel_evt, done_evt;
  logic [ADDR_W-1:0]  base_w, last_w;
  logic               wel_q;

  fes_spi_rx #(.SYNC(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .frame_end(frame_end), .nbits(nbits), .shreg(shreg)
  );

  fes_cmd_decode #(.ADDR_W(ADDR_W), .SIZE_SHIFT(SIZE_SHIFT)) u_dec (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .nbits(nbits), .shreg(shreg),
    .wel(wel_q), .protect(protect), .busy(busy), .start(start_evt),
    .base(base_w), .last(last_w), .set_wel(set_wel_evt)
  );

  fes_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .base(base_w), .last(last_w),
    .busy(busy), .done(done_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wel_q <= 1'b0;
    else if (done_evt)    wel_q <= 1'b0;
    else if (set_wel_evt) wel_q <= 1'b1;
  end

  assign wel = wel_q;

  a_r7_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  a_r4_gated_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> wel_q && !$past(protect));

endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int AW = 12;
  localparam int ASZ = 1 << AW;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, protect = 1'b0;
  logic wr_en, wel, busy;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0, bad = 0;
  int wcnt = 0, bcyc = 0, order_bad = 0, stray = 0, data_bad = 0;
  logic prev_en = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [7:0] mem [ASZ];
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_erase_seq dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .protect(protect), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wel(wel), .busy(busy)
  );

  always @(posedge clk) begin
    if (wr_en) begin
      if (prev_en && wr_addr != AW'(prev_addr + 1)) order_bad++;
      if (!busy) stray++;
      if (wr_data != 8'hFF) data_bad++;
      mem[wr_addr] = wr_data;
      wcnt++;
    end
    if (busy) bcyc++;
    prev_en = wr_en;
    prev_addr = wr_addr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int a);
    return {1'b0, 7'(a * 37 + 5)};
  endfunction

  task automatic fill();
    for (int a = 0; a < ASZ; a++) mem[a] = pat(a);
  endtask

  task automatic spi_send(input logic [39:0] v, input int n);
    cs_n = 1'b0;
    clks(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      clks(HALF);
      sclk = 1'b1;
      clks(HALF);
      sclk = 1'b0;
    end
    clks(HALF);
    cs_n = 1'b1;
  endtask

  // one check: bytes in [b, b+len) are 0xFF, all others keep their fill
  task automatic check_mem(input int b, input int len, input string req);
    int errs = 0, first = -1;
    for (int a = 0; a < ASZ; a++) begin
      logic [7:0] e = (a >= b && a < b + len) ? 8'hFF : pat(a);
      if (mem[a] !== e) begin errs++; if (first < 0) first = a; end
    end
    chk(errs == 0, req, "array contents mismatching bytes (first addr in msg)", errs, 0);
    if (errs != 0) $display("  first wrong byte at %0h", first);
  endtask

  task automatic wren(input string req);
    spi_send(40'h06, 8);
    clks(10);
    chk(wel == 1'b1, req, "wel after write enable", wel, 1);
  endtask

  task automatic do_erase(input logic [39:0] v, input int n, input int len,
                          input int b, input string req);
    int w0, c0, o0, s0, d0, t;
    fill();
    w0 = wcnt; c0 = bcyc; o0 = order_bad; s0 = stray; d0 = data_bad;
    spi_send(v, n);
    clks(6);
    chk(busy == 1'b1, "R7", "busy after CS rise", busy, 1);
    t = 0;
    while (busy && t < 20000) begin clks(1); t++; end
    clks(1);
    chk(wel == 1'b0, "R7", "wel after erase", wel, 0);
    chk(wcnt - w0 == len, req, "bytes written", wcnt - w0, len);
    chk(bcyc - c0 == len, "R6", "busy cycles", bcyc - c0, len);
    chk(order_bad == o0 && stray == s0 && data_bad == d0, "R6",
        "ascending/0xFF/in-busy errors", (order_bad - o0) + (stray - s0) + (data_bad - d0), 0);
    check_mem(b, len, req);
  endtask

  task automatic do_reject(input logic [39:0] v, input int n, input logic exp_wel,
                           input string req);
    int w0;
    fill();
    w0 = wcnt;
    spi_send(v, n);
    clks(20);
    chk(busy == 1'b0 && wcnt == w0, req, "writes after discarded command", wcnt - w0, 0);
    chk(wel == exp_wel, req, "wel after discarded command", wel, exp_wel);
    check_mem(0, 0, req);
  endtask

  task automatic t_busy_ignore();
    int w0, c0, t;
    fill();
    w0 = wcnt; c0 = bcyc;
    spi_send(40'h60, 8);
    clks(6);
    chk(busy == 1'b1, "R8", "busy at chip erase start", busy, 1);
    spi_send(40'h20_000040, 32);
    spi_send(40'h06, 8);
    t = 0;
    while (busy && t < 20000) begin clks(1); t++; end
    clks(30);
    chk(busy == 1'b0, "R8", "busy after ignored commands", busy, 0);
    chk(wcnt - w0 == ASZ, "R8", "bytes written with commands during busy", wcnt - w0, ASZ);
    chk(bcyc - c0 == ASZ, "R8", "busy cycles with commands during busy", bcyc - c0, ASZ);
    chk(wel == 1'b0, "R8", "wel after write enable during busy", wel, 0);
  endtask

  initial begin
    int b;
    fill();
    clks(5);
    chk(busy == 0 && wel == 0 && wr_en == 0, "R10", "busy/wel/wr_en in reset",
        {busy, wel, wr_en}, 0);
    rst_n = 1'b1;
    clks(5);
    chk(busy == 0 && wel == 0 && wr_en == 0, "R10", "busy/wel/wr_en after reset",
        {busy, wel, wr_en}, 0);

    // R5: write enable with a ninth bit does nothing
    do_reject(40'h0C, 9, 1'b0, "R5");
    // R4: no write-enable latch
    do_reject(40'h20_000100, 32, 1'b0, "R4");
    wren("R5");
    // R4: protected
    protect = 1'b1;
    do_reject(40'hD8_000000, 32, 1'b1, "R4");
    protect = 1'b0;
    // R3: short and long block frames
    do_reject(40'h20_0100, 24, 1'b1, "R3");
    do_reject(40'h20_000100_00, 40, 1'b1, "R3");
    // R2: chip erase with an extra bit
    do_reject({31'd0, 8'h60, 1'b1}, 9, 1'b1, "R2");

    // R1: small block, address mid-block
    b = 'hA57 & ~(64 - 1);
    do_erase(40'h20_000A57, 32, 64, b, "R1");
    // R1 / R9: mid block, upper address bits set
    wren("R5");
    b = 'h345 & ~(512 - 1);
    do_erase(40'h52_7F0345, 32, 512, b, "R9");
    // R1: large block, last byte of the array
    wren("R5");
    b = 'hFFF & ~(1024 - 1);
    do_erase(40'hD8_000FFF, 32, 1024, b, "R1");
    // R2: both chip erase opcodes
    wren("R5");
    do_erase(40'h60, 8, ASZ, 0, "R2");
    wren("R5");
    do_erase(40'hC7, 8, ASZ, 0, "R2");
    // R8
    wren("R5");
    t_busy_ignore();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule